// File: doc/BRIEF.md
# SCSI Initiator Register and Command Front End

This block is the byte-wide register front end of a SCSI initiator controller. It has sixteen register slots on a simple memory-mapped bus. A read and a write at the same offset can reach different registers: the status register sits at the same offset as the target ID register, for example. Command bytes written to the command slot are decoded into register updates and into one-cycle start pulses for a transfer engine that lies outside this block.

Bus phase signalling, target behaviour and data movement are not part of the block. Two handshake inputs stand in for them. One reports whether a selection found a target. The other reports that a data transfer has finished.

A single level interrupt output follows the interrupt flag in the status register. That flag is set by the events that report to software. It is cleared by reading the interrupt-cause register, or by a chip reset.

Top module: `scsi_regfront`

## Requirements
- R1: After `rst_n` is released, the status (offset 4), interrupt-cause (5), sequence (6) and FIFO-count (7) registers read 0x00, config1 (offset 8) reads 0x07, offset 0xE reads the identity value 0x04, and `irq` is low.
- R2: A write to offset 4 sets the selection target to bits 2:0 of the data and does not change the status register read at offset 4. Writes to offsets 5, 6, 7, 9, 0xA, 0xD and 0xF change no readable register. Reads at 9, 0xA, 0xD and 0xF return 0x00.
- R3: Writes to offsets 0 and 1 load a shadow transfer count and clear status bit 4 (terminal count). The readable count at offsets 0 and 1 keeps its value until a command byte with bit 7 set (DMA) copies the shadow into it. Offset 3 reads back the last command byte.
- R4: `irq` equals status bit 7. A read of offset 5 clears status bits 7, 6 and 5 and leaves the other status bits unchanged.
- R5: Command 0x01 (flush) sets the interrupt-cause register to 0x08 and the sequence register to 0, empties the FIFO so that offset 7 reads 0, and does not raise `irq`.
- R6: Command 0x03 (bus reset) sets the interrupt-cause register to 0x80. It raises `irq` only when config1 bit 6 is clear.
- R7: Command 0x02 (chip reset) restores every register to its R1 value and empties the FIFO.
- R8: Commands 0x42 and 0x43 (select) pulse `sel_go` for one cycle, with `sel_tgt` holding the target set through offset 4. The response is taken only while a select is pending.
  - On failure: status becomes 0x80, the interrupt-cause register 0x20, and the sequence register 0.
  - On success: the interrupt-cause register becomes 0x18, the sequence register 4, and status bits 7 and 4 are set. Command 0x43 also sets status bits 2:0 to 2 (command phase).
- R9: Command 0x44 (enable selection) clears the interrupt-cause register.
- R10: A write to offset 2 pushes a byte into a FIFO of `FIFO_DEPTH` entries, and a read of offset 2 pops the oldest byte (0x00 when empty). Offset 7 reads the entry count. A write to a full FIFO is dropped and sets status bit 6 (gross error).
- R11: Command 0x10 pulses `xfer_go` for one cycle, with `xfer_dma` equal to bit 7 of the command byte. A DMA transfer command clears status bit 4. When `xfer_done` arrives for a pending transfer, the block:
  - sets status bits 7 and 4;
  - sets the interrupt-cause register to 0x10 and the sequence register to 0;
  - zeroes the readable count at offsets 0 and 1.

  A `xfer_done` with no transfer pending is ignored.
- R12: Command 0x11 (command-complete sequence) sets the interrupt-cause register to 0x08, sets status bits 2:0 to 7 (message in) and raises `irq`. Without bit 7 it also loads the FIFO with two 0x00 bytes. Command 0x12 (message accepted) sets the interrupt-cause register to 0x20 and the sequence register to 0, and raises `irq`.
- R13: Every register change caused by a bus write or a handshake input is visible from the first clock edge after it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (its side effects take effect at the clock edge) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |
| sel_go | output | 1 | One-cycle selection start pulse |
| sel_tgt | output | 3 | Target ID of the pending selection |
| sel_resp_vld | input | 1 | Selection result valid |
| sel_resp_ok | input | 1 | Target found (1) or absent (0) |
| xfer_go | output | 1 | One-cycle transfer start pulse |
| xfer_dma | output | 1 | The last command carried the DMA bit |
| xfer_done | input | 1 | Transfer finished |

## Verification
The bench targets the split read/write map, and would catch a design that lets the target ID write reach the status register. It checks the shadow transfer count, which a design that copies it on every write, rather than on a DMA command, would expose early. It checks the masked bus-reset interrupt and the read-to-clear of the interrupt-cause register; wrong code there shows up as `irq` stuck high, or as error bits that survive the read. It also checks stray handshake pulses that arrive with nothing pending, FIFO overrun at full depth (the lost byte and the gross-error flag), and the exact cycle in which `irq` rises after a command.

// File: rtl/scsi_regfront_pkg.sv
package scsi_regfront_pkg;

    localparam int ADDR_W = 4;
    localparam int TGT_W  = 3;

    // register offsets
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT_MID = 4'h1;
    localparam logic [ADDR_W-1:0] A_FIFO    = 4'h2;
    localparam logic [ADDR_W-1:0] A_CMD     = 4'h3;
    localparam logic [ADDR_W-1:0] A_STAT    = 4'h4;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 4'h5;
    localparam logic [ADDR_W-1:0] A_STEP    = 4'h6;
    localparam logic [ADDR_W-1:0] A_FCNT    = 4'h7;
    localparam logic [ADDR_W-1:0] A_CFGA    = 4'h8;
    localparam logic [ADDR_W-1:0] A_CFGB    = 4'hB;
    localparam logic [ADDR_W-1:0] A_CFGC    = 4'hC;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'hE;

    // status bit positions
    localparam int ST_INT = 7;
    localparam int ST_GE  = 6;
    localparam int ST_PE  = 5;
    localparam int ST_TC  = 4;

    // interrupt-cause codes
    localparam logic [7:0] CAUSE_FC  = 8'h08;
    localparam logic [7:0] CAUSE_BS  = 8'h10;
    localparam logic [7:0] CAUSE_DC  = 8'h20;
    localparam logic [7:0] CAUSE_RST = 8'h80;

    localparam logic [2:0] PH_CMD   = 3'd2;
    localparam logic [2:0] PH_MSGIN = 3'd7;
    localparam logic [7:0] STEP_CMD = 8'h04;
    localparam logic [7:0] ID_VALUE = 8'h04;
    localparam logic [7:0] CFGA_RST = 8'h07;

    typedef enum logic [6:0] {
        OP_NOP     = 7'h00,
        OP_FLUSH   = 7'h01,
        OP_CHIPRST = 7'h02,
        OP_BUSRST  = 7'h03,
        OP_XFER    = 7'h10,
        OP_CPLSEQ  = 7'h11,
        OP_MSGOK   = 7'h12,
        OP_ATN     = 7'h1A,
        OP_SEL     = 7'h42,
        OP_SELSTOP = 7'h43,
        OP_ENSEL   = 7'h44
    } op_e;

    typedef struct packed {
        logic dma;
        logic flush;
        logic chiprst;
        logic busrst;
        logic xfer;
        logic cplseq;
        logic msgok;
        logic sel;
        logic sel_stop;
        logic ensel;
    } cmd_t;

    typedef struct packed {
        logic [7:0]       shd_lo;
        logic [7:0]       shd_mid;
        logic [7:0]       cnt_lo;
        logic [7:0]       cnt_mid;
        logic [7:0]       cnt_hi;
        logic [7:0]       cmd;
        logic [7:0]       stat;
        logic [7:0]       cause;
        logic [7:0]       step;
        logic [7:0]       cfga;
        logic [7:0]       cfgb;
        logic [7:0]       cfgc;
        logic [TGT_W-1:0] tgt_set;
        logic [TGT_W-1:0] tgt_act;
        logic             dma;
        logic             sel_busy;
        logic             sel_stop;
        logic             xfer_busy;
        logic             sel_go;
        logic             xfer_go;
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r        = '0;
        r.cnt_hi = ID_VALUE;
        r.cfga   = CFGA_RST;
        return r;
    endfunction

endpackage

// File: rtl/regfront_cmd_dec.sv
module regfront_cmd_dec
    import scsi_regfront_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       dec
);
    always_comb begin
        dec     = '0;
        dec.dma = cmd_byte[7];
        case (cmd_byte[6:0])
            OP_FLUSH:   dec.flush   = 1'b1;
            OP_CHIPRST: dec.chiprst = 1'b1;
            OP_BUSRST:  dec.busrst  = 1'b1;
            OP_XFER:    dec.xfer    = 1'b1;
            OP_CPLSEQ:  dec.cplseq  = 1'b1;
            OP_MSGOK:   dec.msgok   = 1'b1;
            OP_SEL:     dec.sel     = 1'b1;
            OP_SELSTOP: begin
                dec.sel      = 1'b1;
                dec.sel_stop = 1'b1;
            end
            OP_ENSEL:   dec.ensel   = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/regfront_fifo.sv
module regfront_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       seed_pair,
    input  logic                       push,
    input  logic [7:0]                 push_data,
    input  logic                       pop,
    output logic [7:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rp;
        logic [AW-1:0] wp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t       q, d;
    logic [7:0] mem_q [DEPTH];
    logic       push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && (q.cnt != '0);
    assign count   = q.cnt;
    assign head    = (q.cnt == '0) ? 8'h00 : mem_q[q.rp];

    always_comb begin
        d = q;
        if (clear || seed_pair) begin
            d.rp  = '0;
            d.wp  = seed_pair ? AW'(2) : '0;
            d.cnt = seed_pair ? CW'(2) : '0;
        end else begin
            if (push_ok) d.wp = bump(q.wp);
            if (pop_ok)  d.rp = bump(q.rp);
            d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (seed_pair) begin
            mem_q[0]     <= 8'h00;
            mem_q[AW'(1)] <= 8'h00;
        end else if (!clear && push_ok) begin
            mem_q[q.wp] <= push_data;
        end
    end

    // R10
    fifo_depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R10
    fifo_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear && !seed_pair) |=> full);
endmodule

// File: rtl/regfront_rdmux.sv
module regfront_rdmux
    import scsi_regfront_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cnt_lo,
    input  logic [7:0]        cnt_mid,
    input  logic [7:0]        cnt_hi,
    input  logic [7:0]        fifo_head,
    input  logic [CW-1:0]     fifo_count,
    input  logic [7:0]        cmd,
    input  logic [7:0]        stat,
    input  logic [7:0]        cause,
    input  logic [7:0]        step,
    input  logic [7:0]        cfga,
    input  logic [7:0]        cfgb,
    input  logic [7:0]        cfgc,
    output logic [7:0]        rdata
);
    always_comb begin
        case (addr)
            A_CNT_LO:  rdata = cnt_lo;
            A_CNT_MID: rdata = cnt_mid;
            A_FIFO:    rdata = fifo_head;
            A_CMD:     rdata = cmd;
            A_STAT:    rdata = stat;
            A_CAUSE:   rdata = cause;
            A_STEP:    rdata = step;
            A_FCNT:    rdata = 8'(fifo_count);
            A_CFGA:    rdata = cfga;
            A_CFGB:    rdata = cfgb;
            A_CFGC:    rdata = cfgc;
            A_CNT_HI:  rdata = cnt_hi;
            default:   rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/scsi_regfront.sv
module scsi_regfront
    import scsi_regfront_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [3:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        irq,
    output logic        sel_go,
    output logic [2:0]  sel_tgt,
    input  logic        sel_resp_vld,
    input  logic        sel_resp_ok,
    output logic        xfer_go,
    output logic        xfer_dma,
    input  logic        xfer_done
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    regs_t          q, d;
    cmd_t           dec;
    logic           cmd_wr, rd_cause, sel_evt, xfer_evt, evt_any;
    logic           fifo_clear, fifo_seed, fifo_push, fifo_pop, fifo_full;
    logic [7:0]     fifo_head;
    logic [CW-1:0]  fifo_count;

    regfront_cmd_dec u_dec (
        .cmd_byte (wdata),
        .dec      (dec)
    );

    assign cmd_wr     = wr_en && (addr == A_CMD);
    assign rd_cause   = rd_en && (addr == A_CAUSE);
    assign sel_evt    = sel_resp_vld && q.sel_busy;
    assign xfer_evt   = xfer_done && q.xfer_busy;
    assign evt_any    = cmd_wr || sel_evt || xfer_evt;
    assign fifo_clear = cmd_wr && (dec.flush || dec.chiprst);
    assign fifo_seed  = cmd_wr && dec.cplseq && !dec.dma;
    assign fifo_push  = wr_en && (addr == A_FIFO);
    assign fifo_pop   = rd_en && (addr == A_FIFO);

    regfront_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clear),
        .seed_pair (fifo_seed),
        .push      (fifo_push),
        .push_data (wdata),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    regfront_rdmux #(.CW(CW)) u_rdmux (
        .addr       (addr),
        .cnt_lo     (q.cnt_lo),
        .cnt_mid    (q.cnt_mid),
        .cnt_hi     (q.cnt_hi),
        .fifo_head  (fifo_head),
        .fifo_count (fifo_count),
        .cmd        (q.cmd),
        .stat       (q.stat),
        .cause      (q.cause),
        .step       (q.step),
        .cfga       (q.cfga),
        .cfgb       (q.cfgb),
        .cfgc       (q.cfgc),
        .rdata      (rdata)
    );

    always_comb begin
        d         = q;
        d.sel_go  = 1'b0;
        d.xfer_go = 1'b0;

        // reading the cause register drops interrupt and error flags
        if (rd_cause) begin
            d.stat[ST_INT] = 1'b0;
            d.stat[ST_GE]  = 1'b0;
            d.stat[ST_PE]  = 1'b0;
        end

        if (sel_evt) begin
            d.sel_busy = 1'b0;
            if (sel_resp_ok) begin
                d.cause       = CAUSE_BS | CAUSE_FC;
                d.step        = STEP_CMD;
                d.stat[ST_TC] = 1'b1;
                if (q.sel_stop) d.stat[2:0] = PH_CMD;
            end else begin
                d.stat  = 8'h00;
                d.cause = CAUSE_DC;
                d.step  = 8'h00;
            end
            d.stat[ST_INT] = 1'b1;
        end

        if (xfer_evt) begin
            d.xfer_busy    = 1'b0;
            d.stat[ST_TC]  = 1'b1;
            d.stat[ST_INT] = 1'b1;
            d.cause        = CAUSE_BS;
            d.step         = 8'h00;
            d.cnt_lo       = 8'h00;
            d.cnt_mid      = 8'h00;
        end

        if (wr_en) begin
            case (addr)
                A_CNT_LO: begin
                    d.shd_lo      = wdata;
                    d.stat[ST_TC] = 1'b0;
                end
                A_CNT_MID: begin
                    d.shd_mid     = wdata;
                    d.stat[ST_TC] = 1'b0;
                end
                A_FIFO: begin
                    if (fifo_full) d.stat[ST_GE] = 1'b1;
                end
                A_STAT:   d.tgt_set = wdata[TGT_W-1:0];
                A_CFGA:   d.cfga    = wdata;
                A_CFGB:   d.cfgb    = wdata;
                A_CFGC:   d.cfgc    = wdata;
                A_CNT_HI: d.cnt_hi  = wdata;
                A_CMD: begin
                    d.cmd = wdata;
                    d.dma = dec.dma;
                    if (dec.dma) begin
                        d.cnt_lo  = q.shd_lo;
                        d.cnt_mid = q.shd_mid;
                    end
                    if (dec.flush) begin
                        d.cause = CAUSE_FC;
                        d.step  = 8'h00;
                    end
                    if (dec.busrst) begin
                        d.cause = CAUSE_RST;
                        if (!q.cfga[6]) d.stat[ST_INT] = 1'b1;
                    end
                    if (dec.xfer) begin
                        d.xfer_busy = 1'b1;
                        d.xfer_go   = 1'b1;
                        if (dec.dma) d.stat[ST_TC] = 1'b0;
                    end
                    if (dec.cplseq) begin
                        d.cause        = CAUSE_FC;
                        d.stat[2:0]    = PH_MSGIN;
                        d.stat[ST_INT] = 1'b1;
                        if (dec.dma) d.stat[ST_TC] = 1'b1;
                    end
                    if (dec.msgok) begin
                        d.cause        = CAUSE_DC;
                        d.step         = 8'h00;
                        d.stat[ST_INT] = 1'b1;
                    end
                    if (dec.sel) begin
                        d.sel_busy = 1'b1;
                        d.sel_stop = dec.sel_stop;
                        d.sel_go   = 1'b1;
                        d.tgt_act  = q.tgt_set;
                    end
                    if (dec.ensel) d.cause = 8'h00;
                    if (dec.chiprst) d = regs_reset();
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= regs_reset();
        else        q <= d;
    end

    assign irq      = q.stat[ST_INT];
    assign sel_go   = q.sel_go;
    assign sel_tgt  = q.tgt_act;
    assign xfer_go  = q.xfer_go;
    assign xfer_dma = q.dma;

    // R4
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(evt_any));

    // R4
    cause_read_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cause && !evt_any) |=> !irq);

    // R6
    busrst_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && dec.busrst && q.cfga[6] && !irq && !sel_evt && !xfer_evt) |=> !irq);

    // R8
    sel_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_go |-> $past(cmd_wr && dec.sel));

    // R11
    xfer_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> $past(cmd_wr && dec.xfer));

    // R7
    chiprst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && dec.chiprst) |=> (!irq && fifo_count == '0));
endmodule

// File: tb/sim_scsi_regfront.sv
module sim_scsi_regfront;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, sel_go, xfer_go, xfer_dma;
    logic [2:0] sel_tgt;
    logic       sel_resp_vld = 1'b0, sel_resp_ok = 1'b0, xfer_done = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scsi_regfront #(.FIFO_DEPTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sel_go(sel_go),
        .sel_tgt(sel_tgt), .sel_resp_vld(sel_resp_vld), .sel_resp_ok(sel_resp_ok),
        .xfer_go(xfer_go), .xfer_dma(xfer_dma), .xfer_done(xfer_done)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic exp_rd(input string tag, input logic [3:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic sel_reply(input logic ok);
        @(negedge clk);
        sel_resp_vld = 1'b1; sel_resp_ok = ok;
        @(negedge clk);
        sel_resp_vld = 1'b0;
    endtask

    task automatic xfer_reply();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    // bench model of status after a cause read: bits 7,6,5 drop
    function automatic logic [7:0] after_cause_read(input logic [7:0] s);
        return s & 8'h1F;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, s;
        logic [7:0] mdl [$];
        logic [3:0] ign [7] = '{4'h5, 4'h6, 4'h7, 4'h9, 4'hA, 4'hD, 4'hF};
        void'($urandom(32'h5C51));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        exp_rd("R1 status", 4'h4, 8'h00);
        exp_rd("R1 step", 4'h6, 8'h00);
        exp_rd("R1 fcount", 4'h7, 8'h00);
        exp_rd("R1 cfga", 4'h8, 8'h07);
        exp_rd("R1 id", 4'hE, 8'h04);
        exp_rd("R1 cause", 4'h5, 8'h00);

        // R2 split map, ignored offsets
        wr(4'h4, 8'h05);
        exp_rd("R2 status after id write", 4'h4, 8'h00);
        foreach (ign[i]) wr(ign[i], 8'($urandom));
        exp_rd("R2 rd 9", 4'h9, 8'h00);
        exp_rd("R2 rd A", 4'hA, 8'h00);
        exp_rd("R2 rd D", 4'hD, 8'h00);
        exp_rd("R2 rd F", 4'hF, 8'h00);
        exp_rd("R2 status", 4'h4, 8'h00);
        exp_rd("R2 cause", 4'h5, 8'h00);
        exp_rd("R2 step", 4'h6, 8'h00);
        exp_rd("R2 fcount", 4'h7, 8'h00);

        // R3 shadow count
        wr(4'h0, 8'h34);
        wr(4'h1, 8'h12);
        exp_rd("R3 count before dma", 4'h0, 8'h00);
        wr(4'h3, 8'h80);
        exp_rd("R3 count lo", 4'h0, 8'h34);
        exp_rd("R3 count mid", 4'h1, 8'h12);
        exp_rd("R3 cmd readback", 4'h3, 8'h80);

        // R11 transfer
        wr(4'h3, 8'h90);
        chk("R11 xfer_go", {7'd0, xfer_go}, 8'h01);
        chk("R11 xfer_dma", {7'd0, xfer_dma}, 8'h01);
        xfer_reply();
        chk("R11 irq", {7'd0, irq}, 8'h01);
        exp_rd("R11 status", 4'h4, 8'h90);
        exp_rd("R11 cause", 4'h5, 8'h10);
        chk("R4 irq after cause read", {7'd0, irq}, 8'h00);
        exp_rd("R11 step", 4'h6, 8'h00);
        exp_rd("R11 count lo", 4'h0, 8'h00);
        exp_rd("R11 count mid", 4'h1, 8'h00);
        exp_rd("R4 status keeps TC", 4'h4, after_cause_read(8'h90));
        xfer_reply();
        chk("R11 stray done ignored", {7'd0, irq}, 8'h00);
        wr(4'h0, 8'h01);
        exp_rd("R3 count write clears TC", 4'h4, 8'h00);

        // R6 bus reset masked and unmasked, R13 timing
        wr(4'h8, 8'h47);
        wr(4'h3, 8'h03);
        chk("R6 masked irq", {7'd0, irq}, 8'h00);
        exp_rd("R6 cause", 4'h5, 8'h80);
        wr(4'h8, 8'h07);
        @(negedge clk);
        addr = 4'h3; wdata = 8'h03; wr_en = 1'b1;
        #1 chk("R13 irq before edge", {7'd0, irq}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R13 irq after edge", {7'd0, irq}, 8'h01);
        exp_rd("R6 status", 4'h4, 8'h80);
        exp_rd("R6 cause unmasked", 4'h5, 8'h80);
        chk("R4 irq low", {7'd0, irq}, 8'h00);

        // R9 enable selection
        wr(4'h3, 8'h03);
        wr(4'h3, 8'h44);
        exp_rd("R9 cause cleared", 4'h5, 8'h00);

        // R8 failed select
        wr(4'h4, 8'h02);
        wr(4'h3, 8'h42);
        chk("R8 sel_go", {7'd0, sel_go}, 8'h01);
        chk("R8 sel_tgt", {5'd0, sel_tgt}, 8'h02);
        sel_reply(1'b0);
        chk("R8 fail irq", {7'd0, irq}, 8'h01);
        exp_rd("R8 fail status", 4'h4, 8'h80);
        exp_rd("R8 fail cause", 4'h5, 8'h20);
        exp_rd("R8 fail step", 4'h6, 8'h00);
        // R8 success
        wr(4'h4, 8'hFD);
        wr(4'h3, 8'h42);
        chk("R8 sel_tgt 5", {5'd0, sel_tgt}, 8'h05);
        sel_reply(1'b1);
        exp_rd("R8 ok status", 4'h4, 8'h90);
        exp_rd("R8 ok cause", 4'h5, 8'h18);
        exp_rd("R8 ok step", 4'h6, 8'h04);
        sel_reply(1'b1);
        chk("R8 stray reply ignored", {7'd0, irq}, 8'h00);
        wr(4'h4, 8'h07);
        wr(4'h3, 8'h43);
        chk("R8 sel_tgt 7", {5'd0, sel_tgt}, 8'h07);
        sel_reply(1'b1);
        exp_rd("R8 stop status", 4'h4, 8'h92);
        exp_rd("R8 stop cause", 4'h5, 8'h18);

        // R12 message accepted then command-complete sequence
        wr(4'h3, 8'h12);
        chk("R12 msgok irq", {7'd0, irq}, 8'h01);
        exp_rd("R12 msgok step", 4'h6, 8'h00);
        exp_rd("R12 msgok cause", 4'h5, 8'h20);
        wr(4'h3, 8'h01);
        wr(4'h3, 8'h11);
        exp_rd("R12 cplseq status", 4'h4, 8'h97);
        exp_rd("R12 cplseq fcount", 4'h7, 8'h02);
        exp_rd("R12 cplseq cause", 4'h5, 8'h08);
        exp_rd("R12 byte0", 4'h2, 8'h00);
        exp_rd("R12 byte1", 4'h2, 8'h00);
        exp_rd("R12 drained", 4'h7, 8'h00);

        // R10 random FIFO traffic against a queue model
        for (int k = 0; k < 300; k++) begin
            if (($urandom % 2 == 0) && (mdl.size() < 16)) begin
                v = 8'($urandom);
                wr(4'h2, v);
                mdl.push_back(v);
            end else begin
                rd(4'h2, v);
                if (mdl.size() == 0) chk("R10 empty pop", v, 8'h00);
                else chk("R10 pop order", v, mdl.pop_front());
            end
            if (k % 25 == 0) exp_rd("R10 count", 4'h7, 8'(mdl.size()));
        end
        wr(4'h3, 8'h01);
        mdl.delete();
        for (int k = 0; k < 16; k++) wr(4'h2, 8'(k + 1));
        exp_rd("R10 full count", 4'h7, 8'h10);
        wr(4'h2, 8'hEE);
        rd(4'h4, s);
        chk("R10 overrun GE", s & 8'h40, 8'h40);
        exp_rd("R10 count after overrun", 4'h7, 8'h10);
        rd(4'h5, v);
        rd(4'h4, s);
        chk("R4 GE cleared by cause read", s & 8'h40, 8'h00);
        exp_rd("R10 first kept", 4'h2, 8'h01);

        // R5 flush
        wr(4'h3, 8'h42);
        sel_reply(1'b1);
        rd(4'h5, v);
        wr(4'h3, 8'h01);
        chk("R5 no irq", {7'd0, irq}, 8'h00);
        exp_rd("R5 step", 4'h6, 8'h00);
        exp_rd("R5 fcount", 4'h7, 8'h00);
        exp_rd("R5 cause", 4'h5, 8'h08);

        // R7 chip reset
        wr(4'h8, 8'h55);
        wr(4'hB, 8'h3C);
        wr(4'hE, 8'h9A);
        wr(4'h2, 8'h77);
        exp_rd("R7 hi written", 4'hE, 8'h9A);
        wr(4'h3, 8'h03);
        wr(4'h3, 8'h02);
        chk("R7 irq", {7'd0, irq}, 8'h00);
        exp_rd("R7 cfga", 4'h8, 8'h07);
        exp_rd("R7 cfgb", 4'hB, 8'h00);
        exp_rd("R7 id", 4'hE, 8'h04);
        exp_rd("R7 cmd", 4'h3, 8'h00);
        exp_rd("R7 status", 4'h4, 8'h00);
        exp_rd("R7 fcount", 4'h7, 8'h00);

        // R2 random config traffic with ignored-offset writes
        for (int k = 0; k < 16; k++) begin
            logic [7:0] b, c;
            b = 8'($urandom);
            c = 8'($urandom);
            wr(4'hB, b);
            wr(4'hC, c);
            wr(ign[$urandom % 7], 8'($urandom));
            exp_rd("R2 cfgb", 4'hB, b);
            exp_rd("R2 cfgc", 4'hC, c);
            exp_rd("R2 rd 9 zero", 4'h9, 8'h00);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule